// File: doc/BRIEF.md
# Strobe-Driven Serial Memory Emulator

This block is the device side of a small byte memory. A host reaches it through three active-low bus strobes (select, read, write) and one serial data line. The block runs on a fast system clock. It oversamples the strobes, turns each complete bus cycle into a single read or write event, and runs a small protocol over those events. Every bus cycle moves one bit.

To read, the host shifts in a sixteen-bit address, one write cycle per bit. Each group of eight read cycles that follows returns one byte, most significant bit first. The address then advances by itself. A short pattern made of a read, a write of zero and another read brings the protocol back to its starting point at any moment. The same pattern sets a latch that allows writes.

The data line is split into a value output and an enable output, so the pad outside the block can go to high impedance. Page loading and programming timing are outside this block. A busy input stands in for an ongoing programming cycle. The array is filled from its address after reset, so the data read back can be predicted.

Top module: `serial_mem_emu`

## Requirements
- R1: While bus_sel_n is high, read and write strobes are ignored, no cycle is counted, and sdata_oe stays low.
- R2: sdata_oe is high exactly when bus_sel_n and bus_rd_n were both low three clock edges earlier (two synchronizer stages plus one output register).
- R3: A write cycle is bus_sel_n and bus_wr_n low with bus_rd_n high. It completes on whichever of bus_sel_n or bus_wr_n rises first, and the bit on sdata_i while both were low is taken.
- R4: Sixteen consecutive write cycles form an address, most significant bit first. Only the low 9 bits select the byte. A read cycle before the sixteenth write throws the partial address away.
- R5: After an address, each group of 8 read cycles returns one byte on sdata_o, most significant bit first. After a reset the byte at address a holds a[7:0] XOR 0xA5; filling the array takes 2^9 clocks.
- R6: After the eighth bit of a byte the address increments, wrapping from 0x1FF to 0x000.
- R7: A write cycle carrying 0 that directly follows a read cycle is a protocol reset. It sets wr_latch. wr_latch is cleared only by rst.
- R8: Reads that come before a complete address, or after a protocol reset but before the next complete address, return 1. While prog_busy is high, the protocol reset does not set wr_latch.
- R9: prog_ok is high only when wr_latch is set, wprot_n is high and prog_busy is low.
- R10: A cycle in which bus_sel_n, bus_rd_n and bus_wr_n are all low raises strobe_clash and is otherwise ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the strobes |
| rst | input | 1 | Synchronous active-high reset; restarts the array fill |
| bus_sel_n | input | 1 | Active-low device select |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| sdata_i | input | 1 | Serial data from the host |
| wprot_n | input | 1 | Active-low write protect |
| prog_busy | input | 1 | Stub flag: a programming cycle is running |
| sdata_o | output | 1 | Serial data value toward the host |
| sdata_oe | output | 1 | Output enable for the data pad |
| strobe_clash | output | 1 | Read and write strobes are low together while selected |
| wr_latch | output | 1 | Write-enable latch |
| prog_ok | output | 1 | A new programming cycle may start |

## Verification
The hardest case to reach is the address that begins with a zero right after a read. That write is both the first address bit and a protocol reset. The address must still come out correct, and the read that follows must still give data. The bench reaches this case by sending every address after a reset pattern or after a read. It also checks the cases where strobes stop mid-stream: a half-sent address cut off by a read, a reset in the middle of a byte, and a clashing strobe cycle within a sequential read. A behavioural model tracks the expected bit of every read cycle and the pad enable on every clock.

// File: rtl/smem_pkg.sv
package smem_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_READ,
    CYC_WRITE,
    CYC_CLASH
  } cyc_e;
endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
  parameter int  W       = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta <= RST_VAL;
        q[i] <= RST_VAL;
      end else begin
        meta <= d[i];
        q[i] <= meta;
      end
    end
  end
endmodule

// File: rtl/smem_cycle_dec.sv
module smem_cycle_dec
  import smem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sel_s,
  input  logic rd_s,
  input  logic wr_s,
  input  logic din_s,
  output logic rd_done,
  output logic wr_done,
  output logic wr_bit,
  output logic clash
);
  cyc_e kind;
  logic bit_q;
  logic all_low;

  assign all_low = !sel_s && !rd_s && !wr_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      kind    <= CYC_IDLE;
      bit_q   <= 1'b0;
      rd_done <= 1'b0;
      wr_done <= 1'b0;
      wr_bit  <= 1'b0;
      clash   <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      wr_done <= 1'b0;
      clash   <= all_low;
      unique case (kind)
        CYC_IDLE: begin
          if (all_low) kind <= CYC_CLASH;
          else if (!sel_s && !wr_s) begin
            kind  <= CYC_WRITE;
            bit_q <= din_s;
          end else if (!sel_s && !rd_s) kind <= CYC_READ;
        end
        CYC_WRITE: begin
          if (all_low) kind <= CYC_CLASH;
          else if (sel_s || wr_s) begin
            kind    <= CYC_IDLE;
            wr_done <= 1'b1;
            wr_bit  <= bit_q;
          end else bit_q <= din_s;
        end
        CYC_READ: begin
          if (all_low) kind <= CYC_CLASH;
          else if (sel_s || rd_s) begin
            kind    <= CYC_IDLE;
            rd_done <= 1'b1;
          end
        end
        CYC_CLASH: begin
          if (sel_s || (rd_s && wr_s)) kind <= CYC_IDLE;
        end
        default: kind <= CYC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smem_proto.sv
module smem_proto #(
  parameter int AW       = 9,
  parameter int DW       = 8,
  parameter int SEQ_BITS = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rd_done,
  input  logic                   wr_done,
  input  logic                   wr_bit,
  input  logic                   prog_busy,
  output logic [AW-1:0]          byte_addr,
  output logic [$clog2(DW)-1:0]  bit_idx,
  output logic                   in_read,
  output logic                   wel
);
  localparam int CW = $clog2(SEQ_BITS + 1);
  localparam int BW = $clog2(DW);

  logic [CW-1:0] cnt;
  logic [AW-2:0] sh;
  logic          last_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      sh        <= '0;
      last_rd   <= 1'b0;
      in_read   <= 1'b0;
      byte_addr <= '0;
      bit_idx   <= '0;
      wel       <= 1'b0;
    end else if (wr_done) begin
      last_rd <= 1'b0;
      in_read <= 1'b0;
      sh      <= {sh[AW-3:0], wr_bit};
      if (last_rd || cnt == '0) begin
        cnt <= CW'(1);
      end else if (cnt == CW'(SEQ_BITS - 1)) begin
        cnt       <= '0;
        in_read   <= 1'b1;
        byte_addr <= {sh, wr_bit};
        bit_idx   <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
      if (last_rd && !wr_bit && !prog_busy) wel <= 1'b1;
    end else if (rd_done) begin
      last_rd <= 1'b1;
      cnt     <= '0;
      if (in_read) begin
        bit_idx <= bit_idx + BW'(1);
        if (bit_idx == BW'(DW - 1)) byte_addr <= byte_addr + AW'(1);
      end
    end
  end
endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int         AW       = 9,
  parameter int         DW       = 8,
  parameter logic [7:0] INIT_PAT = 8'hA5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] fill_addr;
  logic          filling;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_addr <= '0;
      filling   <= 1'b1;
    end else if (filling) begin
      fill_addr <= fill_addr + AW'(1);
      if (fill_addr == AW'(DEPTH - 1)) filling <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (filling) mem[fill_addr] <= DW'(fill_addr) ^ DW'(INIT_PAT);
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/serial_mem_emu.sv
module serial_mem_emu #(
  parameter int         ADDR_W   = 9,
  parameter int         DATA_W   = 8,
  parameter int         SEQ_BITS = 16,
  parameter logic [7:0] INIT_PAT = 8'hA5
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_sel_n,
  input  logic bus_rd_n,
  input  logic bus_wr_n,
  input  logic sdata_i,
  input  logic wprot_n,
  input  logic prog_busy,
  output logic sdata_o,
  output logic sdata_oe,
  output logic strobe_clash,
  output logic wr_latch,
  output logic prog_ok
);
  localparam int BW = $clog2(DATA_W);

  logic [4:0]        raw_v, syn_v;
  logic              sel_s, rd_s, wr_s, din_s, wp_s;
  logic              rd_done, wr_done, wr_bit;
  logic [ADDR_W-1:0] byte_addr;
  logic [BW-1:0]     bit_idx;
  logic              in_read;
  logic [DATA_W-1:0] rd_data;

  assign raw_v = {wprot_n, sdata_i, bus_wr_n, bus_rd_n, bus_sel_n};
  assign {wp_s, din_s, wr_s, rd_s, sel_s} = syn_v;

  smem_sync #(.W(5), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(syn_v)
  );

  smem_cycle_dec u_dec (
    .clk(clk), .rst(rst), .sel_s(sel_s), .rd_s(rd_s), .wr_s(wr_s),
    .din_s(din_s), .rd_done(rd_done), .wr_done(wr_done),
    .wr_bit(wr_bit), .clash(strobe_clash)
  );

  smem_proto #(.AW(ADDR_W), .DW(DATA_W), .SEQ_BITS(SEQ_BITS)) u_proto (
    .clk(clk), .rst(rst), .rd_done(rd_done), .wr_done(wr_done),
    .wr_bit(wr_bit), .prog_busy(prog_busy), .byte_addr(byte_addr),
    .bit_idx(bit_idx), .in_read(in_read), .wel(wr_latch)
  );

  smem_array #(.AW(ADDR_W), .DW(DATA_W), .INIT_PAT(INIT_PAT)) u_array (
    .clk(clk), .rst(rst), .rd_addr(byte_addr), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdata_oe <= 1'b0;
      sdata_o  <= 1'b1;
      prog_ok  <= 1'b0;
    end else begin
      sdata_oe <= !sel_s && !rd_s;
      sdata_o  <= in_read ? rd_data[BW'(DATA_W - 1) - bit_idx] : 1'b1;
      prog_ok  <= wr_latch && wp_s && !prog_busy;
    end
  end
endmodule

// File: rtl/serial_mem_emu_chk.sv
module serial_mem_emu_chk (
  input logic clk,
  input logic rst,
  input logic bus_sel_n,
  input logic bus_rd_n,
  input logic bus_wr_n,
  input logic wprot_n,
  input logic sdata_oe,
  input logic strobe_clash,
  input logic wr_latch,
  input logic prog_ok
);
  AST_DRIVE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (rst)
    sdata_oe |-> $past(!bus_sel_n && !bus_rd_n, 3)); // R2
  AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $past(bus_sel_n, 3) |-> !sdata_oe); // R1
  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    wr_latch |=> wr_latch); // R7
  AST_GRANT_NEEDS_WP: assert property (@(posedge clk) disable iff (rst)
    prog_ok |-> $past(wprot_n, 3)); // R9
  AST_GRANT_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    prog_ok |-> $past(wr_latch)); // R9
  AST_CLASH_SOURCE: assert property (@(posedge clk) disable iff (rst)
    strobe_clash |-> $past(!bus_sel_n && !bus_rd_n && !bus_wr_n, 3)); // R10
endmodule

bind serial_mem_emu serial_mem_emu_chk u_chk (.*);

// File: tb/serial_mem_emu_tb.sv
module serial_mem_emu_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
  logic sdata_i = 1'b1, wprot_n = 1'b1, prog_busy = 1'b0;
  logic sdata_o, sdata_oe, strobe_clash, wr_latch, prog_ok;

  int n_chk = 0;
  int n_fail = 0;

  int m_last_rd, m_cnt, m_sh, m_in, m_addr, m_bit, m_wel;
  logic [2:0] oe_hist = 3'b000;

  always #5 clk = ~clk;

  serial_mem_emu u_dut (
    .clk(clk), .rst(rst), .bus_sel_n(bus_sel_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .sdata_i(sdata_i), .wprot_n(wprot_n),
    .prog_busy(prog_busy), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
    .strobe_clash(strobe_clash), .wr_latch(wr_latch), .prog_ok(prog_ok)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // R2: per-clock pad-enable model, three edges of latency
  always @(posedge clk) oe_hist <= {oe_hist[1:0], (!bus_sel_n && !bus_rd_n)};
  always @(negedge clk) if (!rst) chk("R2 pad enable", int'(sdata_oe), int'(oe_hist[2]));

  task automatic model_clear();
    m_last_rd = 0; m_cnt = 0; m_sh = 0; m_in = 0; m_addr = 0; m_bit = 0; m_wel = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    model_clear();
    repeat (600) @(negedge clk);
  endtask

  task automatic bus_wr(input int b, input bit sel_first);
    @(negedge clk);
    sdata_i = b[0]; bus_rd_n = 1'b1; bus_wr_n = 1'b0; bus_sel_n = 1'b0;
    repeat (6) @(negedge clk);
    if (sel_first) begin
      bus_sel_n = 1'b1; repeat (3) @(negedge clk); bus_wr_n = 1'b1;
    end else begin
      bus_wr_n = 1'b1; repeat (3) @(negedge clk); bus_sel_n = 1'b1;
    end
    repeat (6) @(negedge clk);
    m_sh = ((m_sh << 1) | b) & 16'hFFFF;
    if (m_last_rd != 0 && b == 0 && prog_busy == 1'b0) m_wel = 1;
    m_in = 0;
    if (m_last_rd != 0 || m_cnt == 0) m_cnt = 1;
    else if (m_cnt == 15) begin
      m_cnt = 0; m_in = 1; m_addr = m_sh & 511; m_bit = 0;
    end else m_cnt++;
    m_last_rd = 0;
  endtask

  task automatic bus_rd(input string rq);
    int exp;
    exp = (m_in != 0) ? ((((m_addr & 255) ^ 8'hA5) >> (7 - m_bit)) & 1) : 1;
    @(negedge clk);
    bus_wr_n = 1'b1; bus_rd_n = 1'b0; bus_sel_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(rq, int'(sdata_o), exp);
    bus_rd_n = 1'b1; bus_sel_n = 1'b1;
    repeat (6) @(negedge clk);
    m_last_rd = 1; m_cnt = 0;
    if (m_in != 0) begin
      m_bit++;
      if (m_bit == 8) begin m_bit = 0; m_addr = (m_addr + 1) % 512; end
    end
  endtask

  task automatic send_addr(input int a);
    for (int i = 15; i >= 0; i--) bus_wr((a >> i) & 1, i[0]);
  endtask

  task automatic read_byte(input string rq);
    for (int i = 0; i < 8; i++) bus_rd(rq);
  endtask

  task automatic reset_seq();
    bus_rd("R8 pattern read");
    bus_wr(0, 1'b0);
    bus_rd("R8 pattern second read");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset oe", int'(sdata_oe), 0);
    chk("R7 reset latch", int'(wr_latch), 0);
    chk("R10 reset clash", int'(strobe_clash), 0);
    chk("R9 reset grant", int'(prog_ok), 0);
    repeat (600) @(negedge clk);

    // R8: reads before any address return 1
    bus_rd("R8 no address"); bus_rd("R8 no address");

    // R7 / R9: reset pattern sets the latch, write protect gates the grant
    reset_seq();
    chk("R7 latch set", int'(wr_latch), m_wel);
    chk("R9 grant with wp high", int'(prog_ok), 1);
    wprot_n = 1'b0; repeat (5) @(negedge clk);
    chk("R9 grant with wp low", int'(prog_ok), 0);
    wprot_n = 1'b1; prog_busy = 1'b1; repeat (5) @(negedge clk);
    chk("R9 grant while busy", int'(prog_ok), 0);
    prog_busy = 1'b0; repeat (5) @(negedge clk);

    // R3 R4 R5 R6: address 0x012 with mixed edge order, two bytes
    send_addr(16'h0012);
    read_byte("R5 byte 0x012");
    read_byte("R6 next byte 0x013");

    // R1: strobes toggled while deselected change nothing
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); bus_rd_n = 1'b0; repeat (5) @(negedge clk);
      bus_rd_n = 1'b1; bus_wr_n = 1'b0; sdata_i = 1'b0; repeat (5) @(negedge clk);
      bus_wr_n = 1'b1; repeat (3) @(negedge clk);
    end
    chk("R1 deselected oe", int'(sdata_oe), 0);
    read_byte("R1 sequence kept 0x014");

    // R4 R6: upper address bits ignored, wrap at top
    send_addr(16'hFFFF);
    read_byte("R6 byte 0x1FF");
    read_byte("R6 wrap 0x000");

    // R4: partial address aborted by a read
    for (int i = 0; i < 5; i++) bus_wr(1, 1'b0);
    bus_rd("R4 aborted address reads 1");
    send_addr(16'h00A0);
    read_byte("R4 byte 0x0A0");

    // R8: reset in the middle of a byte
    send_addr(16'h0133);
    for (int i = 0; i < 3; i++) bus_rd("R5 partial byte");
    reset_seq();
    bus_rd("R8 after reset reads 1");
    bus_rd("R8 after reset reads 1");

    // R10: clashing cycle ignored
    send_addr(16'h0040);
    for (int i = 0; i < 4; i++) bus_rd("R5 byte 0x040");
    @(negedge clk); bus_sel_n = 1'b0; bus_rd_n = 1'b0; bus_wr_n = 1'b0; sdata_i = 1'b0;
    repeat (6) @(negedge clk);
    chk("R10 clash flag", int'(strobe_clash), 1);
    bus_sel_n = 1'b1; repeat (3) @(negedge clk);
    bus_rd_n = 1'b1; bus_wr_n = 1'b1; repeat (6) @(negedge clk);
    chk("R10 clash cleared", int'(strobe_clash), 0);
    for (int i = 0; i < 4; i++) bus_rd("R10 byte 0x040 continues");

    // R8: protocol reset while busy leaves the latch clear
    do_reset();
    prog_busy = 1'b1;
    reset_seq();
    chk("R8 busy latch", int'(wr_latch), 0);
    chk("R9 busy grant", int'(prog_ok), 0);
    prog_busy = 1'b0;
    send_addr(16'h01C3);
    read_byte("R5 byte 0x1C3 after busy");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule